// File: doc/BRIEF.md
# Synchronous Serial Port Interrupt Controller

This block turns the state of a synchronous serial port's two eight-entry FIFOs into four interrupt requests. Two are level requests: one for transmit FIFO free space and one for receive FIFO fill. Two are event requests. The first is a receive idle timeout, raised when received words have sat unread for 32 bit periods. The second is a sticky receive overrun, raised when a word arrives into a full receive FIFO. Each request has its own mask bit. The block reports raw status, masked status and one combined interrupt, which is the OR of the masked requests.

The shifter, the FIFO storage, the bit clock and the register decode sit outside the block. They reach it only as an occupancy count per FIFO, a port enable, a transfer-active level, a receive-write strobe, a one-cycle bit-rate tick, a mask and a write-one-to-clear pulse for the overrun flag.

The timeout is a three-state machine with a saturating idle counter:
- `TMO_HOLD` has the counter at zero. It moves to `TMO_COUNT` (transition *arm*) when the receive FIFO is non-empty and no transfer is active.
- `TMO_COUNT` returns to `TMO_HOLD` (transition *restart*) on an empty FIFO or an active transfer. Otherwise it moves to `TMO_FIRED` (transition *expire*) on the tick that completes the 32nd idle bit period.
- `TMO_FIRED` returns to `TMO_HOLD` on an empty FIFO (transition *drain*). It also returns to `TMO_HOLD` when a transfer starts while the FIFO has room (transition *resume*). A transfer into a full FIFO keeps it in `TMO_FIRED`.

Top module: `ssp_irq_ctrl`

## Requirements
- R1: Status bit 3 (transmit) is 1 whenever the transmit count is 4 or less, and 0 at 5 to 8 while the port is enabled.
- R2: While the port enable is 0, status bit 3 is 1 whatever the transmit count.
- R3: Status bit 2 (receive) is 1 exactly when the receive count is 4 or more.
- R4: Status bit 1 (timeout) rises in the cycle after the 32nd bit-rate tick counted in `TMO_COUNT`, not after the 31st. It stays high on further ticks.
- R5: An active transfer or an empty receive FIFO restarts the idle count from zero. One idle cycle is spent in `TMO_HOLD` before ticks are counted again.
- R6: A transfer-active cycle while the receive count is between 1 and 7 clears status bit 1 in the next cycle.
- R7: A receive count of zero clears status bit 1 in the next cycle.
- R8: A receive-write strobe while the receive count is 8 sets status bit 0 (overrun) in the next cycle, and a transfer at that count leaves bit 1 set. A strobe at a count below 8 does not set bit 0.
- R9: Bit 0 stays set until a clear pulse. When a clear pulse and a new overrun fall in the same cycle, bit 0 stays set.
- R10: Masked status equals raw status AND mask, bit for bit. The combined interrupt is 1 exactly when any masked bit is 1.
- R11: After reset, bits 1 and 0 of the raw status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_count | input | 4 | Valid entries in the transmit FIFO (0..8) |
| rx_count | input | 4 | Valid entries in the receive FIFO (0..8) |
| port_en | input | 1 | Serial port enable |
| xfer_active | input | 1 | A transfer is in progress |
| rx_wr | input | 1 | Received word written toward the receive FIFO |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| irq_mask | input | 4 | Per-request enable: 3 transmit, 2 receive, 1 timeout, 0 overrun |
| ovr_clr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| raw_stat | output | 4 | Unmasked request status, same bit order |
| masked_stat | output | 4 | raw_stat AND irq_mask |
| irq | output | 1 | OR of masked_stat |

## Verification
Two pairs of events can meet in one cycle, and the bench provokes both. The first pair is an overrun and its clear. A receive-write strobe at a full count is driven together with the clear pulse, and the overrun bit is expected to remain set. The second pair is a timeout and a transfer start. A transfer and a write strobe are driven into a full FIFO while the timeout is set, and in the next cycle the timeout is expected to stay high while the overrun rises.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
    localparam int IRQ_N = 4;
    localparam int B_OVR = 0;
    localparam int B_TMO = 1;
    localparam int B_RX  = 2;
    localparam int B_TX  = 3;

    typedef enum logic [1:0] {
        TMO_HOLD  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_t;
endpackage

// File: rtl/ssp_level_irq.sv
module ssp_level_irq #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          port_en,
    output logic          tx_req,
    output logic          rx_req
);
    localparam int HALF = DEPTH / 2;

    always_comb begin
        tx_req = !port_en || (tx_count <= CW'(HALF));
        rx_req = (rx_count >= CW'(HALF));
    end
endmodule

// File: rtl/ssp_idle_timer.sv
module ssp_idle_timer
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int CW        = 4,
    parameter int IDLE_BITS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_count,
    input  logic          xfer_active,
    input  logic          bit_tick,
    output logic          tmo_req
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);

    tmo_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             rx_empty, rx_full, last_tick;

    always_comb begin
        rx_empty  = (rx_count == '0);
        rx_full   = (rx_count == CW'(DEPTH));
        last_tick = bit_tick && (cnt_q == CNT_W'(IDLE_BITS - 1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMO_HOLD:  if (!rx_empty && !xfer_active) state_d = TMO_COUNT;
            TMO_COUNT: begin
                if (rx_empty || xfer_active) state_d = TMO_HOLD;
                else if (last_tick)          state_d = TMO_FIRED;
            end
            TMO_FIRED: begin
                if (rx_empty)                     state_d = TMO_HOLD;
                else if (xfer_active && !rx_full) state_d = TMO_HOLD;
            end
            default: state_d = TMO_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMO_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     cnt_q <= '0;
        else if (state_q != TMO_COUNT || state_d != TMO_COUNT) begin
            if (state_d != TMO_FIRED)                   cnt_q <= '0;
        end
        else if (bit_tick)                              cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        tmo_req = (state_q == TMO_FIRED);
    end

    // R7
    empty_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !tmo_req);
    // R6
    resume_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && rx_count != '0 && rx_count != CW'(DEPTH)) |=> !tmo_req);
    // R4
    tmo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_req) |-> $past(bit_tick));
    // R8
    full_xfer_keeps_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_req && rx_count == CW'(DEPTH)) |=> tmo_req);
endmodule

// File: rtl/ssp_overrun_flag.sv
module ssp_overrun_flag #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_wr,
    input  logic          ovr_clr,
    output logic          ovr_req
);
    logic hit;

    always_comb hit = rx_wr && (rx_count == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_req <= 1'b0;
        else if (hit)     ovr_req <= 1'b1;
        else if (ovr_clr) ovr_req <= 1'b0;
    end

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ovr_req);
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_req && !ovr_clr) |=> ovr_req);
endmodule

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl
    import ssp_irq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int CW        = 4,
    parameter int IDLE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    tx_count,
    input  logic [CW-1:0]    rx_count,
    input  logic             port_en,
    input  logic             xfer_active,
    input  logic             rx_wr,
    input  logic             bit_tick,
    input  logic [IRQ_N-1:0] irq_mask,
    input  logic             ovr_clr,
    output logic [IRQ_N-1:0] raw_stat,
    output logic [IRQ_N-1:0] masked_stat,
    output logic             irq
);
    logic tx_req, rx_req, tmo_req, ovr_req;

    ssp_level_irq #(.DEPTH(DEPTH), .CW(CW)) u_level (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .port_en  (port_en),
        .tx_req   (tx_req),
        .rx_req   (rx_req)
    );

    ssp_idle_timer #(.DEPTH(DEPTH), .CW(CW), .IDLE_BITS(IDLE_BITS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_count    (rx_count),
        .xfer_active (xfer_active),
        .bit_tick    (bit_tick),
        .tmo_req     (tmo_req)
    );

    ssp_overrun_flag #(.DEPTH(DEPTH), .CW(CW)) u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_count (rx_count),
        .rx_wr    (rx_wr),
        .ovr_clr  (ovr_clr),
        .ovr_req  (ovr_req)
    );

    always_comb begin
        raw_stat        = '0;
        raw_stat[B_TX]  = tx_req;
        raw_stat[B_RX]  = rx_req;
        raw_stat[B_TMO] = tmo_req;
        raw_stat[B_OVR] = ovr_req;
    end

    for (genvar g = 0; g < IRQ_N; g++) begin : g_mask
        assign masked_stat[g] = raw_stat[g] & irq_mask[g];
    end

    assign irq = |masked_stat;

    // R2
    disabled_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> raw_stat[B_TX]);
    // R10
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask != '0));
    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (raw_stat[B_TMO] == 1'b0 && raw_stat[B_OVR] == 1'b0));
endmodule

// File: tb/test_ssp_irq_ctrl.sv
module test_ssp_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tx_count = 4'd8, rx_count = 4'd0;
    logic       port_en = 1'b1, xfer_active = 1'b0, rx_wr = 1'b0, bit_tick = 1'b0;
    logic [3:0] irq_mask = 4'hF;
    logic       ovr_clr = 1'b0;
    logic [3:0] raw_stat, masked_stat;
    logic       irq;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ssp_irq_ctrl i_ssp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
        .port_en(port_en), .xfer_active(xfer_active), .rx_wr(rx_wr),
        .bit_tick(bit_tick), .irq_mask(irq_mask), .ovr_clr(ovr_clr),
        .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq)
    );

    // fields: tx(4) rx(4) en(1) mask(4) raw(4) irq(1)
    localparam logic [17:0] VEC [0:7] = '{
        {4'd0, 4'd0, 1'b1, 4'hF, 4'b1000, 1'b1},   // R1
        {4'd4, 4'd3, 1'b1, 4'hF, 4'b1000, 1'b1},   // R1 boundary
        {4'd5, 4'd3, 1'b1, 4'hF, 4'b0000, 1'b0},   // R1, R3
        {4'd8, 4'd4, 1'b1, 4'hF, 4'b0100, 1'b1},   // R3 boundary
        {4'd8, 4'd8, 1'b1, 4'b1000, 4'b0100, 1'b0}, // R10
        {4'd8, 4'd0, 1'b0, 4'hF, 4'b1000, 1'b1},   // R2
        {4'd5, 4'd7, 1'b0, 4'b0100, 4'b1100, 1'b1}, // R2, R10
        {4'd8, 4'd2, 1'b1, 4'hF, 4'b0000, 1'b0}    // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R11 timeout", {31'd0, raw_stat[1]}, 32'd0);
        chk("R11 overrun", {31'd0, raw_stat[0]}, 32'd0);

        for (int i = 0; i < 8; i++) begin
            tx_count = VEC[i][17:14];
            rx_count = VEC[i][13:10];
            port_en  = VEC[i][9];
            irq_mask = VEC[i][8:5];
            #1;
            chk("R1/R2/R3 raw", {28'd0, raw_stat}, {28'd0, VEC[i][4:1]});
            chk("R10 masked", {28'd0, masked_stat}, {28'd0, VEC[i][4:1] & VEC[i][8:5]});
            chk("R10 irq", {31'd0, irq}, {31'd0, VEC[i][0]});
            @(negedge clk);
        end

        // timeout
        tx_count = 4'd8; port_en = 1'b1; irq_mask = 4'hF;
        rx_count = 4'd0; step(2);
        rx_count = 4'd2; step(1);
        ticks(31);
        chk("R4 not after 31", {31'd0, raw_stat[1]}, 32'd0);
        ticks(1);
        chk("R4 after 32", {31'd0, raw_stat[1]}, 32'd1);
        chk("R10 irq on timeout", {31'd0, irq}, 32'd1);
        ticks(5);
        chk("R4 saturate", {31'd0, raw_stat[1]}, 32'd1);

        xfer_active = 1'b1; @(negedge clk); xfer_active = 1'b0;
        chk("R6 resume clears", {31'd0, raw_stat[1]}, 32'd0);

        step(1); ticks(20);
        xfer_active = 1'b1; @(negedge clk); xfer_active = 1'b0;
        step(1); ticks(31);
        chk("R5 restart after xfer", {31'd0, raw_stat[1]}, 32'd0);
        ticks(1);
        chk("R5 fires after full count", {31'd0, raw_stat[1]}, 32'd1);

        rx_count = 4'd0; @(negedge clk);
        chk("R7 drain clears", {31'd0, raw_stat[1]}, 32'd0);
        rx_count = 4'd2; step(1); ticks(10);
        rx_count = 4'd0; @(negedge clk); rx_count = 4'd2; step(1); ticks(31);
        chk("R5 restart after empty", {31'd0, raw_stat[1]}, 32'd0);
        ticks(1);

        // transfer into full FIFO while timed out
        rx_count = 4'd8; xfer_active = 1'b1; rx_wr = 1'b1;
        @(negedge clk);
        rx_wr = 1'b0;
        chk("R8 timeout kept", {31'd0, raw_stat[1]}, 32'd1);
        chk("R8 overrun set", {31'd0, raw_stat[0]}, 32'd1);
        xfer_active = 1'b0; step(3);
        chk("R9 sticky", {31'd0, raw_stat[0]}, 32'd1);
        irq_mask = 4'b0000; #1;
        chk("R10 all masked", {31'd0, irq}, 32'd0);
        irq_mask = 4'hF;
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk("R9 clear", {31'd0, raw_stat[0]}, 32'd0);
        ovr_clr = 1'b1; rx_wr = 1'b1; @(negedge clk); ovr_clr = 1'b0; rx_wr = 1'b0;
        chk("R9 set beats clear", {31'd0, raw_stat[0]}, 32'd1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        rx_count = 4'd7; rx_wr = 1'b1; @(negedge clk); rx_wr = 1'b0;
        chk("R8 no overrun below full", {31'd0, raw_stat[0]}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule